// File: doc/BRIEF.md
# Debug Command Decoder and Register Block

This block sits between a single-wire debug transceiver and a small processor core stub. Each received byte arrives as a one-cycle strobe. In the idle state the block classifies the byte by its two top bits into one of four groups: flow control, flag load, baud control and register access. Bits that do not take part in the decode are ignored, so every command has several aliases. Register-write and low-byte-write commands then collect one or two operand bytes. Operand bytes are never decoded as commands.

The block holds a program counter, a hardware breakpoint address, a loaded instruction word, a read-only identity word, a low-byte register and a control-flag byte. Each of these is visible as an output. Replies go to the transmitter as a stream with one item per cycle. An item is either a data byte or a break request. The core stub receives one-cycle run, step, execute-loaded-instruction, target-reset and link-disable pulses. Baud commands are passed on to the transceiver with their 6-bit code.

Top module: `dbg_cmd_decoder`

## Requirements
- R1: After reset, pc, bkpt, insn, lo_reg and flags read zero, and no reply item or control pulse is active.
- R2: A byte 1101xxii written while idle (ii selects 0 pc, 1 bkpt, 2 insn, 3 identity; xx ignored) takes a high operand byte and then a low operand byte. The 16-bit value is written to that register once the low byte has arrived. A write to index 3 changes nothing.
- R3: A byte 1111xxii makes the block return the selected register as two reply bytes, high byte then low byte, in the two cycles that follow the command. Index 3 returns the ID parameter.
- R4: A byte 1100xxxx takes one operand byte into lo_reg. A byte 1110xxxx returns lo_reg as one reply byte.
- R5: After any break, whether received or sent, reading index 0 returns pc+1. This holds until pc is next written.
- R6: A byte 00xxxyaa (y not part of a disable or reset code) gives a pulse in the next cycle. aa=0 gives a run pulse, aa=1 a step pulse, aa=2 run with use_insn, aa=3 step with use_insn. Bits 5:3 do not change the action.
- R7: When a flow-control byte has bits 5:4 = 11, the next core_done pulse makes the block emit a break and then byte 0x55. Other flow-control bytes give no reply.
- R8: A flow-control byte whose low three bits are 110 pulses link_disable. If the low three bits are 111, it pulses tgt_reset and replies 0x00, then a break, then 0x55.
- R9: Any byte 01xxxxxx is loaded into flags. Bit 4 drives flag_flow_brk, bit 0 drives flag_bkpt_en, and a clear bit 5 drives flag_timers_run.
- R10: A byte 10xxxxxx pulses baud_set with baud_code equal to bits 5:0 and replies 0x55.
- R11: A byte that arrives while operands are awaited is used as an operand and triggers no action.
- R12: rx_break aborts any partial command, returns the decoder to idle, cancels any awaited completion and replies 0x55.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_break | input | 1 | Break detected on the link |
| core_done | input | 1 | Core stub finished the requested action |
| pc | output | 16 | Program counter register |
| bkpt | output | 16 | Hardware breakpoint register |
| insn | output | 16 | Loaded instruction register |
| lo_reg | output | 8 | Low-byte register |
| flags | output | 8 | Control flag byte |
| flag_flow_brk | output | 1 | Break on change of flow enable |
| flag_timers_run | output | 1 | Timers run while halted |
| flag_bkpt_en | output | 1 | Hardware breakpoint enable |
| tx_valid | output | 1 | Reply byte valid this cycle |
| tx_data | output | 8 | Reply byte |
| tx_break | output | 1 | Break request to transmitter |
| core_run | output | 1 | Run pulse |
| core_step | output | 1 | Single-step pulse |
| core_use_insn | output | 1 | Execute insn first (with run or step) |
| tgt_reset | output | 1 | Target reset pulse |
| link_disable | output | 1 | Debug link disable pulse |
| baud_set | output | 1 | Baud change pulse |
| baud_code | output | 6 | Baud selector |

## Verification
The assertions assume that a new command byte and a core_done pulse never land in the same cycle. They also assume that no reply-producing event happens while an earlier reply sequence is still draining, since the reply queue is loaded whole. The bench waits for every reply to finish before it sends the next byte, and it raises core_done only in a cycle with no receive strobe. Received bytes are one-cycle strobes with at least one idle cycle between them, which keeps the operand collection within what the decoder checks.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  typedef enum logic [1:0] {GRP_FLOW = 2'b00, GRP_FLAG = 2'b01,
                            GRP_BAUD = 2'b10, GRP_REG  = 2'b11} grp_e;
  typedef enum logic [1:0] {TK_NONE, TK_BYTE, TK_BRK} tk_e;
  typedef struct packed {
    tk_e        kind;
    logic [7:0] data;
  } tx_item_t;

  localparam int         SEQ_LEN   = 3;
  localparam logic [7:0] SYNC_BYTE = 8'h55;
  localparam logic [7:0] RST_ACK   = 8'h00;

  function automatic grp_e cmd_group(input logic [7:0] b);
    return grp_e'(b[7:6]);
  endfunction

  function automatic logic is_disable(input logic [7:0] b);
    return b[2:0] == 3'b110;
  endfunction

  function automatic logic is_reset(input logic [7:0] b);
    return b[2:0] == 3'b111;
  endfunction

  function automatic tx_item_t item_byte(input logic [7:0] d);
    tx_item_t t;
    t.kind = TK_BYTE;
    t.data = d;
    return t;
  endfunction

  function automatic tx_item_t item_brk();
    tx_item_t t;
    t.kind = TK_BRK;
    t.data = 8'h00;
    return t;
  endfunction

  function automatic tx_item_t item_none();
    tx_item_t t;
    t.kind = TK_NONE;
    t.data = 8'h00;
    return t;
  endfunction

  // pc as seen by a read: one ahead after a break
  function automatic logic [15:0] pc_view(input logic [15:0] p, input logic after_brk);
    return p + {15'd0, after_brk};
  endfunction
endpackage

// File: rtl/dbg_regfile.sv
module dbg_regfile
  import dbg_pkg::*;
#(
  parameter logic [15:0] ID_WORD = 16'hA5C3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_idx,
  input  logic [15:0] reg_wdata,
  input  logic        lo_we,
  input  logic [7:0]  lo_wdata,
  input  logic        flags_we,
  input  logic [7:0]  flags_wdata,
  input  logic        brk_mark,
  input  logic [1:0]  rd_idx,
  output logic [15:0] rd_data,
  output logic [15:0] pc,
  output logic [15:0] bkpt,
  output logic [15:0] insn,
  output logic [7:0]  lo_reg,
  output logic [7:0]  flags
);
  logic after_brk;
  logic pc_we;
  assign pc_we = reg_we && reg_idx == 2'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc <= '0; bkpt <= '0; insn <= '0; lo_reg <= '0; flags <= '0;
      after_brk <= 1'b0;
    end else begin
      if (reg_we) begin
        case (reg_idx)
          2'd0: pc   <= reg_wdata;
          2'd1: bkpt <= reg_wdata;
          2'd2: insn <= reg_wdata;
          default: ;
        endcase
      end
      if (lo_we)    lo_reg <= lo_wdata;
      if (flags_we) flags  <= flags_wdata;
      if (brk_mark)   after_brk <= 1'b1;
      else if (pc_we) after_brk <= 1'b0;
    end
  end

  always_comb begin
    case (rd_idx)
      2'd0:    rd_data = pc_view(pc, after_brk);
      2'd1:    rd_data = bkpt;
      2'd2:    rd_data = insn;
      default: rd_data = ID_WORD;
    endcase
  end

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_we |=> $stable(pc)); // R2
endmodule

// File: rtl/dbg_tx_seq.sv
module dbg_tx_seq
  import dbg_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   seq_ld,
  input  tx_item_t [SEQ_LEN-1:0] seq,
  output logic                   tx_valid,
  output logic [7:0]             tx_data,
  output logic                   tx_break
);
  tx_item_t [SEQ_LEN-1:0] slots;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SEQ_LEN; i++) slots[i] <= item_none();
    end else if (seq_ld) begin
      slots <= seq;
    end else begin
      for (int i = 0; i < SEQ_LEN - 1; i++) slots[i] <= slots[i+1];
      slots[SEQ_LEN-1] <= item_none();
    end
  end

  assign tx_valid = slots[0].kind == TK_BYTE;
  assign tx_break = slots[0].kind == TK_BRK;
  assign tx_data  = slots[0].data;

  AST_BRK_THEN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    tx_break |=> (tx_valid && tx_data == SYNC_BYTE)); // R7
endmodule

// File: rtl/dbg_cmd_fsm.sv
module dbg_cmd_fsm
  import dbg_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rx_valid,
  input  logic [7:0]             rx_data,
  input  logic                   rx_break,
  input  logic                   core_done,
  input  logic [15:0]            rd_data,
  input  logic [7:0]             lo_val,
  output logic                   reg_we,
  output logic [1:0]             reg_idx,
  output logic [15:0]            reg_wdata,
  output logic                   lo_we,
  output logic                   flags_we,
  output logic                   brk_mark,
  output logic                   seq_ld,
  output tx_item_t [SEQ_LEN-1:0] seq,
  output logic                   core_run,
  output logic                   core_step,
  output logic                   core_use_insn,
  output logic                   tgt_reset,
  output logic                   link_disable,
  output logic                   baud_set,
  output logic [5:0]             baud_code
);
  typedef enum logic [1:0] {ST_IDLE, ST_HI, ST_LO, ST_LOB} st_e;
  st_e        state, state_n;
  logic [1:0] tgt_q, tgt_n;
  logic [7:0] hi_q, hi_n;
  logic       await_q, await_n;
  logic       run_n, step_n, use_n, rst_n_p, dis_n, baud_n;

  logic accept, cmd_ev, opnd_ev, done_ev;
  assign accept  = rx_valid && !rx_break;
  assign cmd_ev  = accept && state == ST_IDLE;
  assign opnd_ev = accept && state != ST_IDLE;
  assign done_ev = core_done && await_q && !rx_break;

  always_comb begin
    state_n = state; tgt_n = tgt_q; hi_n = hi_q; await_n = await_q;
    reg_we = 1'b0; reg_idx = tgt_q; reg_wdata = {hi_q, rx_data};
    lo_we = 1'b0; flags_we = 1'b0; brk_mark = 1'b0; seq_ld = 1'b0;
    for (int i = 0; i < SEQ_LEN; i++) seq[i] = item_none();
    run_n = 1'b0; step_n = 1'b0; use_n = 1'b0;
    rst_n_p = 1'b0; dis_n = 1'b0; baud_n = 1'b0;

    if (rx_break) begin
      state_n = ST_IDLE; await_n = 1'b0; brk_mark = 1'b1;
      seq_ld = 1'b1; seq[0] = item_byte(SYNC_BYTE);
    end else begin
      if (done_ev) begin
        await_n = 1'b0; brk_mark = 1'b1; seq_ld = 1'b1;
        seq[0] = item_brk(); seq[1] = item_byte(SYNC_BYTE);
      end
      if (opnd_ev) begin
        case (state)
          ST_HI:   begin hi_n = rx_data; state_n = ST_LO; end
          ST_LO:   begin reg_we = 1'b1; state_n = ST_IDLE; end
          default: begin lo_we = 1'b1; state_n = ST_IDLE; end
        endcase
      end
      if (cmd_ev) begin
        case (cmd_group(rx_data))
          GRP_FLOW: begin
            if (is_disable(rx_data)) dis_n = 1'b1;
            else if (is_reset(rx_data)) begin
              rst_n_p = 1'b1; brk_mark = 1'b1; seq_ld = 1'b1;
              seq[0] = item_byte(RST_ACK); seq[1] = item_brk();
              seq[2] = item_byte(SYNC_BYTE);
            end else begin
              run_n  = !rx_data[0];
              step_n = rx_data[0];
              use_n  = rx_data[1];
              if (rx_data[5:4] == 2'b11) await_n = 1'b1;
            end
          end
          GRP_FLAG: flags_we = 1'b1;
          GRP_BAUD: begin
            baud_n = 1'b1; seq_ld = 1'b1; seq[0] = item_byte(SYNC_BYTE);
          end
          default: begin
            case (rx_data[5:4])
              2'b01: begin tgt_n = rx_data[1:0]; state_n = ST_HI; end
              2'b00: state_n = ST_LOB;
              2'b11: begin
                seq_ld = 1'b1;
                seq[0] = item_byte(rd_data[15:8]);
                seq[1] = item_byte(rd_data[7:0]);
              end
              default: begin seq_ld = 1'b1; seq[0] = item_byte(lo_val); end
            endcase
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE; tgt_q <= '0; hi_q <= '0; await_q <= 1'b0;
      core_run <= 1'b0; core_step <= 1'b0; core_use_insn <= 1'b0;
      tgt_reset <= 1'b0; link_disable <= 1'b0; baud_set <= 1'b0;
      baud_code <= '0;
    end else begin
      state <= state_n; tgt_q <= tgt_n; hi_q <= hi_n; await_q <= await_n;
      core_run <= run_n; core_step <= step_n; core_use_insn <= use_n;
      tgt_reset <= rst_n_p; link_disable <= dis_n; baud_set <= baud_n;
      if (baud_n) baud_code <= rx_data[5:0];
    end
  end

  AST_BREAK_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_break |=> state == ST_IDLE); // R12
  AST_OPND_NO_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_break && state != ST_IDLE) |=>
      !(core_run || core_step || tgt_reset || link_disable || baud_set)); // R11
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({core_run, core_step, tgt_reset, link_disable, baud_set})); // R6
endmodule

// File: rtl/dbg_cmd_decoder.sv
module dbg_cmd_decoder
  import dbg_pkg::*;
#(
  parameter logic [15:0] ID_WORD = 16'hA5C3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_break,
  input  logic        core_done,
  output logic [15:0] pc,
  output logic [15:0] bkpt,
  output logic [15:0] insn,
  output logic [7:0]  lo_reg,
  output logic [7:0]  flags,
  output logic        flag_flow_brk,
  output logic        flag_timers_run,
  output logic        flag_bkpt_en,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        tx_break,
  output logic        core_run,
  output logic        core_step,
  output logic        core_use_insn,
  output logic        tgt_reset,
  output logic        link_disable,
  output logic        baud_set,
  output logic [5:0]  baud_code
);
  logic        reg_we, lo_we, flags_we, brk_mark, seq_ld;
  logic [1:0]  reg_idx;
  logic [15:0] reg_wdata, rd_data;
  tx_item_t [SEQ_LEN-1:0] seq;

  dbg_cmd_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_break(rx_break), .core_done(core_done), .rd_data(rd_data),
    .lo_val(lo_reg), .reg_we(reg_we), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .lo_we(lo_we), .flags_we(flags_we),
    .brk_mark(brk_mark), .seq_ld(seq_ld), .seq(seq),
    .core_run(core_run), .core_step(core_step),
    .core_use_insn(core_use_insn), .tgt_reset(tgt_reset),
    .link_disable(link_disable), .baud_set(baud_set), .baud_code(baud_code)
  );

  dbg_regfile #(.ID_WORD(ID_WORD)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .lo_we(lo_we), .lo_wdata(rx_data),
    .flags_we(flags_we), .flags_wdata(rx_data), .brk_mark(brk_mark),
    .rd_idx(rx_data[1:0]), .rd_data(rd_data), .pc(pc), .bkpt(bkpt),
    .insn(insn), .lo_reg(lo_reg), .flags(flags)
  );

  dbg_tx_seq u_tx (
    .clk(clk), .rst_n(rst_n), .seq_ld(seq_ld), .seq(seq),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_break(tx_break)
  );

  assign flag_flow_brk   = flags[4];
  assign flag_timers_run = !flags[5];
  assign flag_bkpt_en    = flags[0];
endmodule

// File: tb/dbg_cmd_decoder_bench.sv
module dbg_cmd_decoder_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_valid = 1'b0, rx_break = 1'b0, core_done = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic [15:0] pc, bkpt, insn;
  logic [7:0] lo_reg, flags, tx_data;
  logic flag_flow_brk, flag_timers_run, flag_bkpt_en, tx_valid, tx_break;
  logic core_run, core_step, core_use_insn, tgt_reset, link_disable, baud_set;
  logic [5:0] baud_code;
  int checks = 0, fails = 0;
  bit done = 0;
  localparam logic [15:0] ID = 16'hA5C3;

  always #5 clk = ~clk;

  dbg_cmd_decoder u_dbg_cmd_decoder (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_data = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic brk();
    @(negedge clk); rx_break = 1'b1;
    @(negedge clk); rx_break = 1'b0;
  endtask

  task automatic done_pulse();
    @(negedge clk); core_done = 1'b1;
    @(negedge clk); core_done = 1'b0;
  endtask

  task automatic expect_byte(input string req, input logic [7:0] b);
    chk(req, {tx_valid, tx_break, tx_data}, {2'b10, b});
    @(negedge clk);
  endtask

  task automatic wr16(input logic [7:0] c, input logic [15:0] v);
    send(c); send(v[15:8]); send(v[7:0]);
  endtask

  task automatic rd16(input string req, input logic [7:0] c, input logic [15:0] v);
    send(c); expect_byte(req, v[15:8]); expect_byte(req, v[7:0]);
  endtask

  task automatic t_reset();
    chk("R1 regs", {pc, bkpt, insn, lo_reg, flags}, 0);
    chk("R1 outs", {tx_valid, tx_break, core_run, core_step, tgt_reset, link_disable, baud_set}, 0);
  endtask

  task automatic t_regs();
    wr16(8'hD0, 16'h1234); chk("R2 pc", pc, 16'h1234);
    wr16(8'hDD, 16'hABCD); chk("R2 bkpt alias", bkpt, 16'hABCD);
    wr16(8'hD6, 16'h5566); chk("R2 insn alias", insn, 16'h5566);
    wr16(8'hDF, 16'h1111);
    chk("R2 id write ignored", {pc, bkpt, insn}, {16'h1234, 16'hABCD, 16'h5566});
    rd16("R3 id", 8'hF3, ID);
    rd16("R3 bkpt alias", 8'hF9, 16'hABCD);
    rd16("R3 pc", 8'hFC, 16'h1234);
  endtask

  task automatic t_lo();
    send(8'hC5); send(8'h5A); chk("R4 lo", lo_reg, 8'h5A);
    send(8'hE9); expect_byte("R4 read", 8'h5A);
  endtask

  task automatic t_pc_brk();
    brk(); expect_byte("R12 sync", 8'h55);
    rd16("R5 pc+1", 8'hF0, 16'h1235);
    wr16(8'hD0, 16'h0010);
    rd16("R5 cleared", 8'hF0, 16'h0010);
  endtask

  task automatic t_flow();
    send(8'h00); chk("R6 run", {core_run, core_step, core_use_insn}, 3'b100);
    send(8'h29); chk("R6 step alias", {core_run, core_step, core_use_insn}, 3'b010);
    send(8'h1A); chk("R6 run insn", {core_run, core_step, core_use_insn}, 3'b101);
    chk("R7 no reply", {tx_valid, tx_break}, 0);
    send(8'h0B); chk("R6 step insn", {core_run, core_step, core_use_insn}, 3'b011);
  endtask

  task automatic t_complete();
    send(8'h30); chk("R7 go", core_run, 1);
    done_pulse(); chk("R7 break", {tx_valid, tx_break}, 2'b01);
    @(negedge clk); expect_byte("R7 sync", 8'h55);
    send(8'h10); done_pulse();
    chk("R7 no break", {tx_valid, tx_break}, 0);
    @(negedge clk); chk("R7 no break 2", {tx_valid, tx_break}, 0);
  endtask

  task automatic t_rst_dis();
    send(8'h2E); chk("R8 disable", {link_disable, tgt_reset}, 2'b10);
    send(8'h17); chk("R8 reset", {link_disable, tgt_reset}, 2'b01);
    expect_byte("R8 ack", 8'h00);
    chk("R8 break", {tx_valid, tx_break}, 2'b01);
    @(negedge clk); expect_byte("R8 sync", 8'h55);
  endtask

  task automatic t_flags();
    send(8'h79); chk("R9 flags", flags, 8'h79);
    chk("R9 fields", {flag_flow_brk, flag_timers_run, flag_bkpt_en}, 3'b101);
    send(8'h42); chk("R9 flags2", flags, 8'h42);
    chk("R9 fields2", {flag_flow_brk, flag_timers_run, flag_bkpt_en}, 3'b010);
  endtask

  task automatic t_baud();
    send(8'hA2); chk("R10 baud", {baud_set, baud_code}, {1'b1, 6'h22});
    expect_byte("R10 sync", 8'h55);
  endtask

  task automatic t_operand();
    send(8'hD1); send(8'h30); chk("R11 no run", core_run, 0);
    send(8'h07); chk("R11 no reset", {tgt_reset, tx_valid, tx_break}, 0);
    chk("R11 bkpt", bkpt, 16'h3007);
  endtask

  task automatic t_abort();
    send(8'hD0); send(8'h77); brk(); expect_byte("R12 sync", 8'h55);
    send(8'h30); chk("R12 decoded after abort", core_run, 1);
    chk("R12 pc kept", pc, 16'h0010);
    brk(); @(negedge clk); done_pulse();
    chk("R12 await cancelled", {tx_valid, tx_break}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset(); t_regs(); t_lo(); t_pc_brk(); t_flow(); t_complete();
    t_rst_dis(); t_flags(); t_baud(); t_operand(); t_abort();
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule